// File: doc/BRIEF.md
# Four-Way Write-Through Word Cache

This block sits between a processor port and a slow memory port. It keeps copies of single 32-bit memory words. Each copy is tagged with the upper bits of its full memory address. The words are spread over eight sets of four ways, and all four ways of the selected set are compared at once. A read that finds its word answers one cycle after the request. A read that does not find it holds the processor off until the memory port returns the word. That word is then installed in a free way of the set, or, when the set is full, in a way picked by a free-running pseudo-random generator.

Every store goes straight to memory, and the processor is held until the memory port acknowledges it. A store to a word that is already cached also refreshes the cached copy. A store to a word that is not cached leaves the cache contents alone. Only one memory transaction is ever outstanding. Processor requests that arrive while one is open are dropped, and the processor must present them again later.

Top module: `cache_sa_wt`

## Requirements
- R1: The processor address is split into tag = addr[31:5] and set = addr[4:2]. Bits [1:0] play no part in lookup, and the memory port always receives the address with bits [1:0] forced to zero.
- R2: Reset invalidates every line, so the first read of any address after reset is a miss. Out of reset, cpu_ready and mem_req are low.
- R3: A lookup hits only when a way of the selected set is valid and its stored tag equals the request tag. At most one way of a set can match.
- R4: A read hit raises cpu_ready with the cached word on cpu_rdata in the cycle after the request is accepted, and it opens no memory transaction.
- R5: A read miss raises mem_req with mem_we=0 in the cycle after acceptance. mem_req and mem_addr hold until mem_ready. cpu_ready then rises in the next cycle with the returned word, and a later read of that address hits.
- R6: A miss installs into the lowest-numbered invalid way of its set when one exists. Four different tags read into one set therefore all stay resident.
- R7: A miss into a full set replaces exactly one way, chosen from the low bits of a free-running LFSR. The new word hits afterwards, and exactly one of the earlier four words no longer does.
- R8: A write raises mem_req with mem_we=1, the word address and cpu_wdata. cpu_ready stays low until the cycle after mem_ready.
- R9: A write that hits replaces the cached word, so a later read hits and returns the written value without a memory read.
- R10: A write that misses allocates no line, so a later read of that address misses.
- R11: A request presented while a fill or write is in progress is ignored and causes no memory transaction.
- R12: Sets are independent. A word with the same tag but a different set misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, sampled when the cache is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 32 | Read result, valid with cpu_ready |
| mem_req | output | 1 | Memory transaction open |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory completion strobe |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
Two things can happen in the same clock edge: a fill completes and installs its word, while a new processor request is being presented. The bench keeps a write request asserted across the edge on which the memory model acknowledges a read miss. It then judges the outcome from three observations. No memory write may follow, the model memory must keep its old value, and the read must still return the filled word, which must hit on the next read.

// File: rtl/cache_pkg.sv
package cache_pkg;

    localparam int OFS_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } ctl_st_e;

endpackage

// File: rtl/cache_lfsr.sv
module cache_lfsr #(
    parameter int            LFSR_W = 8,
    parameter int            OUT_W  = 2,
    parameter logic [LFSR_W-1:0] TAPS = 8'hB8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [OUT_W-1:0]  rnd
);
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {lfsr_q[LFSR_W-2:0], ^(lfsr_q & TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= LFSR_W'(1);
        else        lfsr_q <= lfsr_d;
    end

    assign rnd = lfsr_q[OUT_W-1:0];
endmodule

// File: rtl/cache_tag_cmp.sv
module cache_tag_cmp #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 27
) (
    input  logic [WAYS-1:0]            valid_row,
    input  logic [WAYS-1:0][TAG_W-1:0] tag_row,
    input  logic [TAG_W-1:0]           tag_in,
    output logic [WAYS-1:0]            hit_vec
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = valid_row[w] && (tag_row[w] == tag_in);
    end
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  valid_row,
    input  logic [WAY_W-1:0] rnd,
    output logic [WAY_W-1:0] victim
);
    logic found;

    always_comb begin
        victim = rnd;
        found  = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid_row[w] && !found) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cache_sa_wt.sv
module cache_sa_wt #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WAYS   = 4,
    parameter int SETS   = 8,
    parameter int LFSR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    import cache_pkg::*;

    localparam int IDX_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int TAG_W   = ADDR_W - IDX_W - OFS_W;
    localparam int WADDR_W = ADDR_W - OFS_W;

    typedef struct packed {
        ctl_st_e                                st;
        logic                                   rdy;
        logic [DATA_W-1:0]                      rdata;
        logic                                   mreq;
        logic                                   we;
        logic [WADDR_W-1:0]                     waddr;
        logic [DATA_W-1:0]                      wdata;
        logic [WAY_W-1:0]                       way;
        logic [SETS-1:0][WAYS-1:0]              valid;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag;
        logic [SETS-1:0][WAYS-1:0][DATA_W-1:0]  data;
    } regs_t;

    regs_t q, d;

    logic [IDX_W-1:0]  req_idx, lat_idx;
    logic [TAG_W-1:0]  req_tag, lat_tag;
    logic [WAYS-1:0]   hit_vec;
    logic              hit_any;
    logic [WAY_W-1:0]  hit_way, victim, rnd;
    logic [DATA_W-1:0] hit_data;
    logic [OFS_W-1:0]  unused_ofs;

    assign req_idx    = cpu_addr[OFS_W +: IDX_W];
    assign req_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
    assign lat_idx    = q.waddr[IDX_W-1:0];
    assign lat_tag    = q.waddr[WADDR_W-1 -: TAG_W];
    assign unused_ofs = cpu_addr[OFS_W-1:0];

    cache_lfsr #(.LFSR_W(LFSR_W), .OUT_W(WAY_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    cache_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
        .valid_row (q.valid[req_idx]),
        .tag_row   (q.tag[req_idx]),
        .tag_in    (req_tag),
        .hit_vec   (hit_vec)
    );

    cache_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_vic (
        .valid_row (q.valid[req_idx]),
        .rnd       (rnd),
        .victim    (victim)
    );

    always_comb begin
        hit_any  = |hit_vec;
        hit_way  = '0;
        hit_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way  = WAY_W'(w);
                hit_data = hit_data | q.data[req_idx][w];
            end
        end
    end

    always_comb begin
        d     = q;
        d.rdy = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    d.waddr = cpu_addr[ADDR_W-1:OFS_W];
                    d.wdata = cpu_wdata;
                    d.we    = cpu_we;
                    if (cpu_we) begin
                        d.st   = ST_WRITE;
                        d.mreq = 1'b1;
                        if (hit_any) d.data[req_idx][hit_way] = cpu_wdata;
                    end else if (hit_any) begin
                        d.rdy   = 1'b1;
                        d.rdata = hit_data;
                    end else begin
                        d.st   = ST_FILL;
                        d.mreq = 1'b1;
                        d.way  = victim;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ready) begin
                    d.valid[lat_idx][q.way] = 1'b1;
                    d.tag[lat_idx][q.way]   = lat_tag;
                    d.data[lat_idx][q.way]  = mem_rdata;
                    d.rdata = mem_rdata;
                    d.rdy   = 1'b1;
                    d.mreq  = 1'b0;
                    d.st    = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    d.rdy  = 1'b1;
                    d.mreq = 1'b0;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cpu_ready = q.rdy;
    assign cpu_rdata = q.rdata;
    assign mem_req   = q.mreq;
    assign mem_we    = q.we;
    assign mem_addr  = {q.waddr, {OFS_W{1'b0}}};
    assign mem_wdata = q.wdata;
endmodule

// File: rtl/cache_sa_wt_chk.sv
module cache_sa_wt_chk #(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WAYS-1:0]   hit_vec
);
    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R3

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R5

    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready |=> cpu_ready && !mem_req); // R8

    AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready); // R11

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R1
endmodule

bind cache_sa_wt cache_sa_wt_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .hit_vec   (hit_vec)
);

// File: tb/sim_cache_sa_wt.sv
`timescale 1ns/1ps
module sim_cache_sa_wt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0, bad = 0, rd_cnt = 0, wr_cnt = 0, lat = 2;
    bit done = 0;
    logic [31:0] memv [logic [31:0]];

    always #2.5 clk = ~clk;

    cache_sa_wt u0 (.*);

    function automatic logic [31:0] mget(input logic [31:0] a);
        if (memv.exists(a)) return memv[a];
        return (a ^ 32'h5A5A_0000) + 32'd7;
    endfunction

    function automatic logic [31:0] mk(input logic [26:0] tag, input logic [2:0] set);
        return {tag, set, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // memory model
    always begin
        @(negedge clk);
        if (mem_req && !mem_ready) begin
            repeat (lat) @(negedge clk);
            if (mem_we) begin
                memv[mem_addr] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata = mget(mem_addr);
                rd_cnt++;
            end
            mem_ready = 1'b1;
            @(negedge clk);
            mem_ready = 1'b0;
        end
    end

    task automatic wait_ready();
        for (int i = 0; i < 50 && !cpu_ready; i++) @(negedge clk);
    endtask

    // read; returns whether it hit
    task automatic do_read(input logic [31:0] a, input string req, output bit hit);
        logic [31:0] exp;
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = a;
        @(negedge clk);
        cpu_req = 0;
        exp = mget({a[31:2], 2'b00});
        hit = cpu_ready;
        if (!hit) begin
            chk(mem_req && !mem_we, req, {31'd0, mem_we}, 32'd0);
            chk(mem_addr == {a[31:2], 2'b00}, req, mem_addr, {a[31:2], 2'b00});
            wait_ready();
        end else begin
            chk(!mem_req, req, {31'd0, mem_req}, 32'd0);
        end
        chk(cpu_ready && cpu_rdata == exp, req, cpu_rdata, exp);
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] v, input string req);
        int w0;
        w0 = wr_cnt;
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = v;
        @(negedge clk);
        cpu_req = 0;
        chk(mem_req && mem_we && mem_wdata == v && !cpu_ready, req, mem_wdata, v);
        wait_ready();
        chk(cpu_ready && wr_cnt == w0 + 1 && memv[{a[31:2], 2'b00}] == v, req, memv[{a[31:2], 2'b00}], v);
    endtask

    task automatic t_reset();
        chk(!cpu_ready && !mem_req, "R2 reset", {30'd0, cpu_ready, mem_req}, 32'd0);
    endtask

    task automatic t_basic();
        bit h;
        logic [31:0] a;
        a = mk(27'h123, 3'd1);
        do_read(a, "R2 cold miss", h);
        chk(!h, "R2 cold miss", {31'd0, h}, 32'd0);
        do_read(a, "R4 hit", h);
        chk(h, "R4 hit", {31'd0, h}, 32'd1);
        do_read(a | 32'd3, "R1 offset ignored", h);
        chk(h, "R1 offset ignored", {31'd0, h}, 32'd1);
        do_read(mk(27'h123, 3'd2), "R12 other set", h);
        chk(!h, "R12 other set", {31'd0, h}, 32'd0);
        do_read(mk(27'h124, 3'd1), "R3 tag differs", h);
        chk(!h, "R3 tag differs", {31'd0, h}, 32'd0);
        do_read(a, "R3 both resident", h);
        chk(h, "R3 both resident", {31'd0, h}, 32'd1);
    endtask

    task automatic t_full_set();
        bit h, found;
        lat = 1;
        for (int k = 0; k < 4; k++) begin
            do_read(mk(27'h400 + 27'(k), 3'd0), "R6 fill way", h);
            chk(!h, "R6 fill way", {31'd0, h}, 32'd0);
        end
        for (int k = 0; k < 4; k++) begin
            do_read(mk(27'h400 + 27'(k), 3'd0), "R6 all resident", h);
            chk(h, "R6 all resident", {31'd0, h}, 32'd1);
        end
        do_read(mk(27'h500, 3'd0), "R7 replace", h);
        chk(!h, "R7 replace", {31'd0, h}, 32'd0);
        do_read(mk(27'h500, 3'd0), "R7 new hits", h);
        chk(h, "R7 new hits", {31'd0, h}, 32'd1);
        found = 0;
        for (int k = 0; k < 4 && !found; k++) begin
            do_read(mk(27'h400 + 27'(k), 3'd0), "R7 probe", h);
            if (!h) found = 1;
        end
        chk(found, "R7 one evicted", {31'd0, found}, 32'd1);
    endtask

    task automatic t_writes();
        bit h;
        int r0;
        logic [31:0] a, b;
        a = mk(27'h123, 3'd1);
        lat = 3;
        do_write(a, 32'hCAFE_0001, "R8 write hit");
        r0 = rd_cnt;
        do_read(a, "R9 cached update", h);
        chk(h && rd_cnt == r0, "R9 cached update", {31'd0, h}, 32'd1);
        b = mk(27'h777, 3'd5);
        do_write(b, 32'hBEEF_0002, "R8 write miss");
        do_read(b, "R10 no allocate", h);
        chk(!h, "R10 no allocate", {31'd0, h}, 32'd0);
    endtask

    task automatic t_ignore();
        int w0;
        bit h;
        logic [31:0] a, c;
        a = mk(27'h0AB, 3'd3);
        c = mk(27'h0CD, 3'd4);
        lat = 3;
        w0 = wr_cnt;
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = a;
        @(negedge clk);
        cpu_we = 1; cpu_addr = c; cpu_wdata = 32'h1111_2222;
        wait_ready();
        cpu_req = 0;
        chk(cpu_ready && cpu_rdata == mget(a), "R11 fill completes", cpu_rdata, mget(a));
        repeat (8) @(negedge clk);
        chk(wr_cnt == w0 && !memv.exists(c) && !mem_req, "R11 request ignored", wr_cnt, w0);
        do_read(a, "R11 fill kept", h);
        chk(h, "R11 fill kept", {31'd0, h}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_basic();
        t_full_set();
        t_writes();
        t_ignore();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule